// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block takes eighteen interrupt request sources and merges them into ten vectors. Four of the sources are external pins, each with a configurable trigger. The other fourteen are single-cycle request pulses from on-chip peripherals. Each vector has an enable bit and a priority bit. The pair of vectors fed only by the first two pins can run at low or highest level. Every other vector can run at low or high level.

A nested in-service record sets which vectors are eligible. A vector may only be raised when its level is strictly above the deepest level now being serviced. Among eligible vectors, the highest level wins. Within a level, the lowest vector number wins.

The CPU side of the block has four signals. The block raises a request line and presents a vector address. The CPU takes the interrupt with an acknowledge strobe and closes it with a return strobe.

A two-state machine controls the request line:
- S_IDLE shows no request. It moves to S_ASSERT (select) as soon as an eligible winner exists.
- In S_ASSERT the block drives the latched winner.
  - It stays in S_ASSERT (reselect) while a winner exists, reloading the winner every cycle.
  - It returns to S_IDLE on acknowledge (take). The take pushes the winner's level and clears its latched flags.
  - It also returns to S_IDLE when no eligible winner remains (withdraw).

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, irq_req is 0, irq_vec_addr is 00h and no level is in service; while irq_req is 0 the address reads 00h.
- R2: A requested vector v (0 to 9) is presented at address 03h + 8*v. Pins 0 to 3 therefore map to 03h, 0Bh, 13h and 1Bh, and vector 9 maps to 4Bh.
- R3: Vector membership is fixed.
  - Pins 0 and 1 feed vectors 0 and 1.
  - Pin 2 and int_src[0] feed vector 2. Pin 3 and int_src[1] feed vector 3.
  - int_src[2] feeds vector 4, int_src[4:3] feed vector 5 and int_src[6:5] feed vector 6.
  - int_src[8:7] feed vector 7, int_src[11:9] feed vector 8 and int_src[13:12] feed vector 9.
- R4: A vector whose vec_en bit is 0 is never requested. A pulse that arrives while the vector is disabled stays pending and is requested once the vector is enabled.
- R5: For vectors 0 and 1, vec_pri=1 selects highest level and 0 selects low. For vectors 2 to 9, vec_pri=1 selects high level and 0 selects low.
- R6: Among eligible vectors, the highest level wins. Between vectors of equal level, the lower vector number wins.
- R7: A vector is requested only if its level is strictly above the deepest level in service, so a higher level request preempts a lower one that is in service.
- R8: irq_ret ends the deepest level in service. A request blocked by that level is then raised again if its level is above the new deepest level.
- R9: The trigger codes for trig_cfg[3p+2:3p] are as follows.
  - 0 is rising edge, 1 is falling edge and 2 is both edges.
  - 3 is high level and 4 is low level.
  - An edge latches a pending flag, and acknowledging the vector clears that flag.
- R10: In a level mode the pin is pending for as long as it holds its active level. Acknowledging the vector does not clear it, so after the return it is requested again if still active.
- R11: Pins 0 and 1 ignore code 2. Pins 2 and 3 ignore codes 3 and 4. All pins ignore codes 5 to 7. An ignored code produces no request.
- R12: An acknowledge clears every latched flag of the vector taken, including all sources that share that vector.
- R13: irq_req is 0 in the cycle after an acknowledge. irq_req also falls when its winner stops being eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 4 | Raw external interrupt pins |
| int_src | input | 14 | Peripheral request pulses, one cycle each |
| vec_en | input | 10 | Per-vector enable |
| vec_pri | input | 10 | Per-vector priority bit |
| trig_cfg | input | 12 | Trigger code, 3 bits per pin |
| irq_ack | input | 1 | CPU takes the presented vector |
| irq_ret | input | 1 | CPU returns from the deepest level |
| irq_req | output | 1 | Interrupt request to CPU |
| irq_vec_addr | output | 8 | Address of the requested vector |

## Verification
The hardest state to reach from the ports is a request held back by a deeper in-service level and then released as the returns unwind the nesting one step at a time.

The stimulus builds that state in order:
1. It takes a low vector, then preempts it with a high vector and takes that one.
2. It pulses a second low source and shows that source is blocked.
3. It shows the source stays blocked after the first return and appears only after the second return.

Highest level is reached the same way, by raising a pin while a high vector is in service. Level-triggered pins are checked across an acknowledge and a return to confirm that the pending state is not cleared.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    parameter int NUM_EXT    = 4;
    parameter int NUM_INT    = 14;
    parameter int NUM_VEC    = 10;
    parameter int LEVEL_PINS = 2;
    parameter int NUM_LVL    = 4;
    parameter int ADDR_W     = 8;
    parameter int VEC_BASE   = 3;
    parameter int VEC_STEP   = 8;
    parameter int CFG_W      = 3;
    localparam int VIDX_W    = $clog2(NUM_VEC);

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_TOP  = 2'd3
    } lvl_t;

    typedef enum logic [CFG_W-1:0] {
        TRG_RISE = 3'd0,
        TRG_FALL = 3'd1,
        TRG_BOTH = 3'd2,
        TRG_HIGH = 3'd3,
        TRG_LOW  = 3'd4
    } trg_t;

    function automatic int src_vec(input int i);
        case (i)
            0:          return 2;
            1:          return 3;
            2:          return 4;
            3, 4:       return 5;
            5, 6:       return 6;
            7, 8:       return 7;
            9, 10, 11:  return 8;
            default:    return 9;
        endcase
    endfunction

    function automatic lvl_t vec_level(input int v, input logic pri);
        if (v < LEVEL_PINS) return pri ? LVL_TOP : LVL_LOW;
        return pri ? LVL_HIGH : LVL_LOW;
    endfunction
endpackage

// File: rtl/irqc_ext_trig.sv
module irqc_ext_trig
    import irqc_pkg::*;
#(
    parameter bit LEVEL_PIN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic [CFG_W-1:0] mode,
    input  logic             clr,
    output logic             pend
);
    logic s1, s2, prev, flag;
    logic rise, fall, hit, edge_mode, lvl_mode, lvl_act;

    assign rise = s2 & ~prev;
    assign fall = ~s2 & prev;

    always_comb begin
        hit = 1'b0;
        edge_mode = 1'b0;
        lvl_mode = 1'b0;
        lvl_act = 1'b0;
        case (mode)
            TRG_RISE: begin edge_mode = 1'b1; hit = rise; end
            TRG_FALL: begin edge_mode = 1'b1; hit = fall; end
            TRG_BOTH: if (!LEVEL_PIN) begin edge_mode = 1'b1; hit = rise | fall; end
            TRG_HIGH: if (LEVEL_PIN) begin lvl_mode = 1'b1; lvl_act = s2; end
            TRG_LOW:  if (LEVEL_PIN) begin lvl_mode = 1'b1; lvl_act = ~s2; end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            prev <= 1'b0;
            flag <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            prev <= s2;
            if (!edge_mode)  flag <= 1'b0;
            else if (hit)    flag <= 1'b1;
            else if (clr)    flag <= 1'b0;
        end
    end

    assign pend = lvl_mode ? lvl_act : flag;
endmodule

// File: rtl/irqc_src_latch.sv
module irqc_src_latch
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_INT-1:0] src,
    input  logic [NUM_VEC-1:0] clr_vec,
    output logic [NUM_VEC-1:0] vec_pend
);
    logic [NUM_INT-1:0] flag;

    for (genvar i = 0; i < NUM_INT; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  flag[i] <= 1'b0;
            else if (src[i])             flag[i] <= 1'b1;
            else if (clr_vec[src_vec(i)]) flag[i] <= 1'b0;
        end
    end

    always_comb begin
        vec_pend = '0;
        for (int i = 0; i < NUM_INT; i++) begin
            if (flag[i]) vec_pend[src_vec(i)] = 1'b1;
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [NUM_VEC-1:0] pend,
    input  logic [NUM_VEC-1:0] en,
    input  logic [NUM_VEC-1:0] pri,
    input  lvl_t               cur_lvl,
    output logic               win_valid,
    output logic [VIDX_W-1:0]  win_idx,
    output lvl_t               win_lvl
);
    lvl_t lvl_v [NUM_VEC];

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_lvl
        assign lvl_v[g] = vec_level(g, pri[g]);
    end

    always_comb begin
        win_valid = 1'b0;
        win_idx = '0;
        win_lvl = LVL_NONE;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (pend[v] && en[v] && (lvl_v[v] > cur_lvl) && (lvl_v[v] >= win_lvl)) begin
                win_valid = 1'b1;
                win_idx = VIDX_W'(v);
                win_lvl = lvl_v[v];
            end
        end
    end
endmodule

// File: rtl/irqc_lvl_stack.sv
module irqc_lvl_stack
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  lvl_t push_lvl,
    input  logic pop,
    output lvl_t cur_lvl
);
    logic [NUM_LVL-1:1] in_svc, in_svc_d;

    always_comb begin
        cur_lvl = LVL_NONE;
        for (int l = 1; l < NUM_LVL; l++) begin
            if (in_svc[l]) cur_lvl = lvl_t'(l);
        end
    end

    always_comb begin
        in_svc_d = in_svc;
        if (pop && cur_lvl != LVL_NONE) in_svc_d[cur_lvl] = 1'b0;
        if (push && push_lvl != LVL_NONE) in_svc_d[push_lvl] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_svc <= '0;
        else        in_svc <= in_svc_d;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EXT-1:0]       ext_pin,
    input  logic [NUM_INT-1:0]       int_src,
    input  logic [NUM_VEC-1:0]       vec_en,
    input  logic [NUM_VEC-1:0]       vec_pri,
    input  logic [NUM_EXT*CFG_W-1:0] trig_cfg,
    input  logic                     irq_ack,
    input  logic                     irq_ret,
    output logic                     irq_req,
    output logic [ADDR_W-1:0]        irq_vec_addr
);
    typedef enum logic [0:0] {S_IDLE, S_ASSERT} st_t;

    st_t               state_q, state_d;
    logic [VIDX_W-1:0] vidx_q, vidx_d;
    lvl_t              vlvl_q, vlvl_d;
    logic              ack_fire;

    logic [NUM_EXT-1:0] ext_pend;
    logic [NUM_VEC-1:0] int_pend, vec_pend, clr_vec;
    logic               win_valid;
    logic [VIDX_W-1:0]  win_idx;
    lvl_t               win_lvl;
    lvl_t               cur_lvl;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_clr
        assign clr_vec[v] = ack_fire && (vidx_q == VIDX_W'(v));
    end

    for (genvar p = 0; p < NUM_EXT; p++) begin : g_ext
        irqc_ext_trig #(.LEVEL_PIN(p < LEVEL_PINS)) u_trig (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (ext_pin[p]),
            .mode (trig_cfg[p*CFG_W +: CFG_W]),
            .clr  (clr_vec[p]),
            .pend (ext_pend[p])
        );
    end

    irqc_src_latch u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (int_src),
        .clr_vec (clr_vec),
        .vec_pend(int_pend)
    );

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_merge
        if (v < NUM_EXT) begin : g_with_pin
            assign vec_pend[v] = int_pend[v] | ext_pend[v];
        end else begin : g_no_pin
            assign vec_pend[v] = int_pend[v];
        end
    end

    irqc_arbiter u_arb (
        .pend     (vec_pend),
        .en       (vec_en),
        .pri      (vec_pri),
        .cur_lvl  (cur_lvl),
        .win_valid(win_valid),
        .win_idx  (win_idx),
        .win_lvl  (win_lvl)
    );

    irqc_lvl_stack u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (ack_fire),
        .push_lvl(vlvl_q),
        .pop     (irq_ret),
        .cur_lvl (cur_lvl)
    );

    always_comb begin
        state_d = state_q;
        vidx_d = vidx_q;
        vlvl_d = vlvl_q;
        ack_fire = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (win_valid) begin
                    state_d = S_ASSERT;
                    vidx_d = win_idx;
                    vlvl_d = win_lvl;
                end
            end
            S_ASSERT: begin
                if (irq_ack) begin
                    ack_fire = 1'b1;
                    state_d = S_IDLE;
                end else if (!win_valid) begin
                    state_d = S_IDLE;
                end else begin
                    vidx_d = win_idx;
                    vlvl_d = win_lvl;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            vidx_q <= '0;
            vlvl_q <= LVL_NONE;
        end else begin
            state_q <= state_d;
            vidx_q <= vidx_d;
            vlvl_q <= vlvl_d;
        end
    end

    always_comb begin
        irq_req = (state_q == S_ASSERT);
        irq_vec_addr = irq_req ? ADDR_W'(VEC_BASE + int'(vidx_q) * VEC_STEP) : '0;
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               irq_req,
    input logic [ADDR_W-1:0]  irq_vec_addr,
    input logic               irq_ack,
    input logic [NUM_VEC-1:0] vec_en,
    input logic [NUM_VEC-1:0] vec_pri,
    input lvl_t               cur_lvl
);
    logic [NUM_VEC-1:0] en_q, pri_q;
    logic [ADDR_W-1:0]  off;
    logic [VIDX_W-1:0]  vidx;
    logic [1:0]         req_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            pri_q <= '0;
        end else begin
            en_q <= vec_en;
            pri_q <= vec_pri;
        end
    end

    assign off = irq_vec_addr - ADDR_W'(VEC_BASE);
    assign vidx = VIDX_W'(off >> $clog2(VEC_STEP));
    assign req_lvl = (int'(vidx) < LEVEL_PINS) ? (pri_q[vidx] ? 2'd3 : 2'd1)
                                               : (pri_q[vidx] ? 2'd2 : 2'd1);

    p_idle_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec_addr == '0));

    p_addr_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((off % VEC_STEP) == 0 && int'(vidx) < NUM_VEC));

    p_enabled_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> en_q[vidx]);

    p_level_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (req_lvl > 2'(cur_lvl)));

    p_drop_after_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);
endmodule

bind irq_vector_ctrl irqc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .irq_vec_addr(irq_vec_addr),
    .irq_ack     (irq_ack),
    .vec_en      (vec_en),
    .vec_pri     (vec_pri),
    .cur_lvl     (cur_lvl)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ext_pin = '0;
    logic [13:0] int_src = '0;
    logic [9:0]  vec_en = '0;
    logic [9:0]  vec_pri = '0;
    logic [11:0] trig_cfg = 12'hFFF;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vec_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string    tag;
        bit       req;
        bit [7:0] addr;
    } item_t;
    item_t sb_q[$];

    int exp_vec[14] = '{2, 3, 4, 5, 5, 6, 6, 7, 7, 8, 8, 8, 9, 9};

    always #2.5 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .int_src(int_src),
        .vec_en(vec_en), .vec_pri(vec_pri), .trig_cfg(trig_cfg),
        .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .irq_vec_addr(irq_vec_addr)
    );

    function automatic bit [7:0] vaddr(input int v);
        return 8'(3 + 8 * v);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input bit req, input bit [7:0] addr);
        item_t it;
        it.tag = tag;
        it.req = req;
        it.addr = addr;
        sb_q.push_back(it);
    endtask

    task automatic pulse_src(input int i);
        int_src[i] = 1'b1;
        tick(1);
        int_src = '0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
    endtask

    task automatic do_ret();
        irq_ret = 1'b1;
        tick(1);
        irq_ret = 1'b0;
    endtask

    task automatic set_mode(input int p, input bit [2:0] m);
        trig_cfg[p*3 +: 3] = m;
    endtask

    task automatic clean();
        vec_en = '0;
        vec_pri = '0;
        trig_cfg = 12'hFFF;
        ext_pin = '0;
        tick(4);
    endtask

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (irq_req !== it.req || (it.req && irq_vec_addr !== it.addr)
                    || (!it.req && irq_vec_addr !== 8'h00)) begin
                    errors++;
                    $display("FAIL %s: req=%0b addr=%02h expected req=%0b addr=%02h",
                             it.tag, irq_req, irq_vec_addr, it.req, it.req ? it.addr : 8'h00);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1: actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        expect_out("R1 reset", 1'b0, 8'h00);
        rst_n = 1'b1;
        tick(3);
        expect_out("R1 after reset", 1'b0, 8'h00);

        // R2 R3: every internal source lands on its vector
        vec_en = '1;
        for (int i = 0; i < 14; i++) begin
            pulse_src(i);
            tick(3);
            expect_out($sformatf("R3 src%0d", i), 1'b1, vaddr(exp_vec[i]));
            do_ack();
            expect_out("R13 drop after ack", 1'b0, 8'h00);
            do_ret();
            tick(2);
        end
        clean();

        // R12: shared vector cleared as a whole
        vec_en = '1;
        pulse_src(3);
        pulse_src(4);
        tick(3);
        expect_out("R12 shared vec", 1'b1, vaddr(5));
        do_ack();
        tick(3);
        expect_out("R12 none left in service", 1'b0, 8'h00);
        do_ret();
        tick(3);
        expect_out("R12 none left after ret", 1'b0, 8'h00);
        clean();

        // R4: disabled vector keeps pending
        vec_en = '1;
        vec_en[6] = 1'b0;
        pulse_src(5);
        tick(4);
        expect_out("R4 disabled", 1'b0, 8'h00);
        vec_en[6] = 1'b1;
        tick(3);
        expect_out("R4 enabled later", 1'b1, vaddr(6));
        do_ack();
        do_ret();
        clean();

        // R6: tie by vector number, then higher level beats lower number
        vec_en = '1;
        pulse_src(2);
        pulse_src(9);
        tick(3);
        expect_out("R6 lower number wins", 1'b1, vaddr(4));
        do_ack();
        do_ret();
        tick(3);
        expect_out("R6 remaining", 1'b1, vaddr(8));
        do_ack();
        do_ret();
        vec_pri[8] = 1'b1;
        pulse_src(2);
        pulse_src(9);
        tick(3);
        expect_out("R6 higher level wins", 1'b1, vaddr(8));
        do_ack();
        tick(3);
        expect_out("R7 low blocked by high", 1'b0, 8'h00);
        do_ret();
        tick(3);
        expect_out("R8 low after ret", 1'b1, vaddr(4));
        do_ack();
        do_ret();
        clean();

        // R7 R8: nesting low then high, blocked low unwinds
        vec_en = '1;
        vec_pri[7] = 1'b1;
        pulse_src(5);
        tick(3);
        expect_out("R7 low taken", 1'b1, vaddr(6));
        do_ack();
        pulse_src(7);
        tick(3);
        expect_out("R7 high preempts", 1'b1, vaddr(7));
        do_ack();
        pulse_src(12);
        tick(3);
        expect_out("R7 low blocked", 1'b0, 8'h00);
        do_ret();
        tick(3);
        expect_out("R8 still blocked by low", 1'b0, 8'h00);
        do_ret();
        tick(3);
        expect_out("R8 released", 1'b1, vaddr(9));
        do_ack();
        do_ret();
        clean();

        // R5: pin 0 highest above high, pin 1 low under high
        vec_en = '1;
        vec_pri[5] = 1'b1;
        vec_pri[0] = 1'b1;
        set_mode(0, 3'd0);
        set_mode(1, 3'd0);
        pulse_src(3);
        tick(3);
        expect_out("R5 high vec", 1'b1, vaddr(5));
        do_ack();
        ext_pin[0] = 1'b1;
        tick(6);
        expect_out("R5 highest over high", 1'b1, vaddr(0));
        do_ack();
        do_ret();
        do_ret();
        ext_pin[0] = 1'b0;
        tick(4);
        pulse_src(3);
        tick(3);
        do_ack();
        ext_pin[1] = 1'b1;
        tick(6);
        expect_out("R5 pin1 low under high", 1'b0, 8'h00);
        do_ret();
        tick(3);
        expect_out("R5 pin1 after ret", 1'b1, vaddr(1));
        do_ack();
        do_ret();
        clean();

        // R9: edge modes on pins 2 and 3
        vec_en = '1;
        set_mode(2, 3'd1);
        ext_pin[2] = 1'b1;
        tick(6);
        expect_out("R9 falling ignores rise", 1'b0, 8'h00);
        ext_pin[2] = 1'b0;
        tick(6);
        expect_out("R9 falling", 1'b1, vaddr(2));
        do_ack();
        expect_out("R9 cleared", 1'b0, 8'h00);
        do_ret();
        set_mode(3, 3'd2);
        ext_pin[3] = 1'b1;
        tick(6);
        expect_out("R9 both rise", 1'b1, vaddr(3));
        do_ack();
        do_ret();
        tick(3);
        expect_out("R9 edge flag gone", 1'b0, 8'h00);
        ext_pin[3] = 1'b0;
        tick(6);
        expect_out("R9 both fall", 1'b1, vaddr(3));
        do_ack();
        do_ret();
        clean();

        // R10: level modes
        vec_en = '1;
        set_mode(0, 3'd3);
        ext_pin[0] = 1'b1;
        tick(6);
        expect_out("R10 high level", 1'b1, vaddr(0));
        do_ack();
        tick(3);
        expect_out("R10 blocked in service", 1'b0, 8'h00);
        do_ret();
        tick(3);
        expect_out("R10 held level again", 1'b1, vaddr(0));
        ext_pin[0] = 1'b0;
        tick(5);
        expect_out("R13 withdrawn", 1'b0, 8'h00);
        ext_pin[1] = 1'b1;
        tick(4);
        set_mode(1, 3'd4);
        tick(5);
        expect_out("R10 low level inactive", 1'b0, 8'h00);
        ext_pin[1] = 1'b0;
        tick(6);
        expect_out("R10 low level", 1'b1, vaddr(1));
        do_ack();
        ext_pin[1] = 1'b1;
        tick(4);
        do_ret();
        tick(4);
        expect_out("R10 low level released", 1'b0, 8'h00);
        clean();

        // R11: codes a pin does not support
        vec_en = '1;
        set_mode(0, 3'd2);
        ext_pin[0] = 1'b1;
        tick(6);
        expect_out("R11 pin0 both rise", 1'b0, 8'h00);
        ext_pin[0] = 1'b0;
        tick(6);
        expect_out("R11 pin0 both fall", 1'b0, 8'h00);
        set_mode(2, 3'd3);
        ext_pin[2] = 1'b1;
        tick(6);
        expect_out("R11 pin2 high level", 1'b0, 8'h00);
        ext_pin[2] = 1'b0;
        set_mode(2, 3'd4);
        tick(6);
        expect_out("R11 pin2 low level", 1'b0, 8'h00);
        set_mode(3, 3'd6);
        ext_pin[3] = 1'b1;
        tick(6);
        ext_pin[3] = 1'b0;
        tick(6);
        expect_out("R11 pin3 code 6", 1'b0, 8'h00);
        clean();

        tick(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule